// File: doc/BRIEF.md
# Four-Channel DMA Programming Register File

This block holds the registers a host programs before a four-channel DMA engine moves any data. The host reaches it over a narrow I/O bus with 8-bit data and a 4-bit port offset. Each channel owns a 16-bit address and a 16-bit count. Both have a base copy and a current copy. A 6-bit mode field and a mask bit complete the channel's state. Because the bus carries one byte at a time, a single byte pointer shared by all channels decides whether an address or count access touches the low or the high byte. Software puts that pointer into a known state by writing a dedicated port.

Masks, modes and software requests are not reached through per-channel ports. They are written as command bytes that name a channel in their two low bits. A few more ports handle the remaining functions: a command register, a status register that latches per-channel terminal count, a temporary register, mask-wide clear and load, and a master clear. The transfer engine is outside the block. Its current-value updates, its terminal-count pulses and its temporary-register load appear here as plain input ports, and the programmed state is driven out to it.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset all four masks are set (chanMask = 4'b1111), the byte pointer selects the low byte, and command, request, status, temporary, mode, address and count registers read zero.
- R2: Channel n's address port is offset 2n and its count port is offset 2n+1 (n = 0..3). A write loads the selected byte into both the base and the current copy. A read returns the selected byte of the current copy.
- R3: The byte pointer is shared by all channels. It selects the low byte first and the high byte next, and it toggles on every read or write of offsets 0x0 to 0x7.
- R4: Any write to offset 0xC returns the byte pointer to the low-byte state.
- R5: A write to offset 0xA picks the channel in data bits 1:0. It sets that channel's mask when bit 2 is 1 and clears it when bit 2 is 0.
- R6: A write to offset 0xB stores data bits 7:2 as the mode of the channel in bits 1:0, driven on chanMode[6n+5:6n].
- R7: A write to offset 0x8 loads the command register (cmdReg). A read of offset 0x8 returns status, whose bits 3:0 are per-channel terminal count and bits 7:4 are the pending requests.
- R8: A pulse on engTc[n] sets status bit n. The bit stays set until status is read, and a read clears bits 3:0. A pulse in the same cycle as the read wins.
- R9: A write to offset 0x9 picks the channel in data bits 1:0 and sets (bit 2 = 1) or clears (bit 2 = 0) its pending request, shown on reqPend.
- R10: A write to offset 0xE clears all four masks. A write to offset 0xF loads the masks from data bits 3:0.
- R11: A write to offset 0xD (master clear) sets all masks and clears the byte pointer and the command, status, request and temporary registers. Addresses, counts and modes are kept.
- R12: engTempLd loads engTempData into the temporary register, and a read of offset 0xD returns it.
- R13: engUpd[n] loads engAddr and engCount into channel n's current copies only. A host write to that channel's address or count port in the same cycle takes precedence for that register.
- R14: Reads of offsets 0x9, 0xA, 0xB, 0xC, 0xE and 0xF return zero and leave the byte pointer unchanged. When read and write enables are both high, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Port offset |
| busWrData | input | 8 | Write data byte |
| busWrEn | input | 1 | Write strobe, one cycle per access |
| busRdEn | input | 1 | Read strobe, one cycle per access |
| busRdData | output | 8 | Read data for the offset presented |
| engUpd | input | 4 | Per-channel load of current address and count from the engine |
| engAddr | input | 16 | Engine's new current address |
| engCount | input | 16 | Engine's new current count |
| engTc | input | 4 | Per-channel terminal-count pulse |
| engTempLd | input | 1 | Load strobe for the temporary register |
| engTempData | input | 8 | Value for the temporary register |
| chanMask | output | 4 | Per-channel mask |
| chanMode | output | 24 | Six mode bits per channel, channel n at bits 6n+5:6n |
| cmdReg | output | 8 | Command register |
| reqPend | output | 4 | Pending software requests |
| baseAddr | output | 64 | Base addresses, channel n at bits 16n+15:16n |
| baseCount | output | 64 | Base counts, same packing |
| curAddr | output | 64 | Current addresses, same packing |
| curCount | output | 64 | Current counts, same packing |

## Verification
The bench mixes accesses to different channels so that the shared byte pointer is exercised across channels. A design that kept one pointer per channel would return the low byte where the high one is expected. It also reads unused offsets mid-sequence, which catches a pointer that toggles on any access. Terminal count is pulsed in the same cycle as a status read. A design that lets the read's clear win loses that event, and status then reads zero. Master clear is issued with the pointer in the high state and with the command, request and mask registers all non-default, so any register left out of the clear shows up at the ports. An engine update and a host byte write hit the same channel in one cycle. This exposes wrong precedence, and also an engine update that leaks into the base copy.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  localparam int CH_NUM = 4;
  localparam int CH_W   = 2;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 6;
  localparam int PORT_W = 4;

  // Port offsets whose values are fixed by the programming model
  localparam logic [PORT_W-1:0] OFS_CMD     = 4'h8;
  localparam logic [PORT_W-1:0] OFS_REQ     = 4'h9;
  localparam logic [PORT_W-1:0] OFS_MASK1   = 4'hA;
  localparam logic [PORT_W-1:0] OFS_MODE    = 4'hB;
  localparam logic [PORT_W-1:0] OFS_CLRPTR  = 4'hC;
  localparam logic [PORT_W-1:0] OFS_MCLR    = 4'hD;
  localparam logic [PORT_W-1:0] OFS_CLRMASK = 4'hE;
  localparam logic [PORT_W-1:0] OFS_LDMASK  = 4'hF;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_ADDR,
    RD_COUNT,
    RD_STATUS,
    RD_TEMP
  } rdSel_e;

  typedef struct packed {
    logic            wrAddr;
    logic            wrCount;
    logic            wrCmd;
    logic            wrReq;
    logic            wrMask1;
    logic            wrMode;
    logic            masterClr;
    logic            clrMasks;
    logic            ldMasks;
    logic            rdStatus;
    logic [CH_W-1:0] portChan;
    logic            hiByte;
    rdSel_e          rdSel;
  } strobe_t;

endpackage

// File: rtl/dma_regs_ctrl.sv
module dma_regs_ctrl
  import dma_regs_pkg::*;
#(
  parameter int PORT_BITS = PORT_W,
  parameter int CH_BITS   = CH_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PORT_BITS-1:0] busAddr,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  output strobe_t              stb
);

  logic wrAct;
  logic rdAct;
  logic chanPort;
  logic isCountPort;
  logic ptrHigh;
  logic ptrClear;
  logic ptrStep;

  // A write takes precedence when both strobes are present
  assign wrAct       = busWrEn;
  assign rdAct       = busRdEn && !busWrEn;
  assign chanPort    = !busAddr[PORT_BITS-1];
  assign isCountPort = busAddr[0];

  assign ptrClear = wrAct && (busAddr == OFS_CLRPTR || busAddr == OFS_MCLR);
  assign ptrStep  = (wrAct || rdAct) && chanPort;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrHigh <= 1'b0;
    end else if (ptrClear) begin
      ptrHigh <= 1'b0;
    end else if (ptrStep) begin
      ptrHigh <= !ptrHigh;
    end
  end

  always_comb begin
    stb           = '0;
    stb.hiByte    = ptrHigh;
    stb.portChan  = busAddr[CH_BITS:1];
    stb.wrAddr    = wrAct && chanPort && !isCountPort;
    stb.wrCount   = wrAct && chanPort && isCountPort;
    stb.wrCmd     = wrAct && (busAddr == OFS_CMD);
    stb.wrReq     = wrAct && (busAddr == OFS_REQ);
    stb.wrMask1   = wrAct && (busAddr == OFS_MASK1);
    stb.wrMode    = wrAct && (busAddr == OFS_MODE);
    stb.masterClr = wrAct && (busAddr == OFS_MCLR);
    stb.clrMasks  = wrAct && (busAddr == OFS_CLRMASK);
    stb.ldMasks   = wrAct && (busAddr == OFS_LDMASK);
    stb.rdStatus  = rdAct && (busAddr == OFS_CMD);
    if (chanPort) begin
      stb.rdSel = isCountPort ? RD_COUNT : RD_ADDR;
    end else if (busAddr == OFS_CMD) begin
      stb.rdSel = RD_STATUS;
    end else if (busAddr == OFS_MCLR) begin
      stb.rdSel = RD_TEMP;
    end else begin
      stb.rdSel = RD_NONE;
    end
  end

endmodule

// File: rtl/dma_regs_data.sv
module dma_regs_data
  import dma_regs_pkg::*;
#(
  parameter int NCH   = CH_NUM,
  parameter int WW    = WORD_W,
  parameter int BW    = BYTE_W,
  parameter int MW    = MODE_W,
  parameter int CHB   = CH_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BW-1:0]     wrData,
  output logic [BW-1:0]     rdData,
  input  logic [NCH-1:0]    engUpd,
  input  logic [WW-1:0]     engAddr,
  input  logic [WW-1:0]     engCount,
  input  logic [NCH-1:0]    engTc,
  input  logic              engTempLd,
  input  logic [BW-1:0]     engTempData,
  output logic [NCH-1:0]    chanMask,
  output logic [NCH*MW-1:0] chanMode,
  output logic [BW-1:0]     cmdReg,
  output logic [NCH-1:0]    reqPend,
  output logic [NCH*WW-1:0] baseAddr,
  output logic [NCH*WW-1:0] baseCount,
  output logic [NCH*WW-1:0] curAddr,
  output logic [NCH*WW-1:0] curCount
);

  localparam int HI_LSB = WW - BW;

  logic [CHB-1:0]         cmdChan;
  logic [NCH-1:0]         tcLatch;
  logic [BW-1:0]          tempReg;
  logic [NCH-1:0][WW-1:0] curAddrArr;
  logic [NCH-1:0][WW-1:0] curCountArr;
  logic [WW-1:0]          rdWord;

  assign cmdChan = wrData[CHB-1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          hitAddr;
    logic          hitCount;
    logic          hitCmd;
    logic [WW-1:0] bAddr;
    logic [WW-1:0] cAddr;
    logic [WW-1:0] bCount;
    logic [WW-1:0] cCount;
    logic [MW-1:0] mode;
    logic          mask;
    logic          req;
    logic          tc;

    assign hitAddr  = stb.wrAddr && (stb.portChan == CHB'(i));
    assign hitCount = stb.wrCount && (stb.portChan == CHB'(i));
    assign hitCmd   = (cmdChan == CHB'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bAddr <= '0;
        cAddr <= '0;
      end else if (hitAddr) begin
        if (stb.hiByte) begin
          bAddr[WW-1:HI_LSB] <= wrData;
          cAddr[WW-1:HI_LSB] <= wrData;
        end else begin
          bAddr[BW-1:0] <= wrData;
          cAddr[BW-1:0] <= wrData;
        end
      end else if (engUpd[i]) begin
        cAddr <= engAddr;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bCount <= '0;
        cCount <= '0;
      end else if (hitCount) begin
        if (stb.hiByte) begin
          bCount[WW-1:HI_LSB] <= wrData;
          cCount[WW-1:HI_LSB] <= wrData;
        end else begin
          bCount[BW-1:0] <= wrData;
          cCount[BW-1:0] <= wrData;
        end
      end else if (engUpd[i]) begin
        cCount <= engCount;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mode <= '0;
      end else if (stb.wrMode && hitCmd) begin
        mode <= wrData[BW-1:BW-MW];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mask <= 1'b1;
      end else if (stb.masterClr) begin
        mask <= 1'b1;
      end else if (stb.clrMasks) begin
        mask <= 1'b0;
      end else if (stb.ldMasks) begin
        mask <= wrData[i];
      end else if (stb.wrMask1 && hitCmd) begin
        mask <= wrData[CHB];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        req <= 1'b0;
      end else if (stb.masterClr) begin
        req <= 1'b0;
      end else if (stb.wrReq && hitCmd) begin
        req <= wrData[CHB];
      end
    end

    // A new terminal count outranks the clear caused by a status read
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tc <= 1'b0;
      end else if (stb.masterClr) begin
        tc <= 1'b0;
      end else if (engTc[i]) begin
        tc <= 1'b1;
      end else if (stb.rdStatus) begin
        tc <= 1'b0;
      end
    end

    assign curAddrArr[i]           = cAddr;
    assign curCountArr[i]          = cCount;
    assign baseAddr[i*WW +: WW]    = bAddr;
    assign baseCount[i*WW +: WW]   = bCount;
    assign curAddr[i*WW +: WW]     = cAddr;
    assign curCount[i*WW +: WW]    = cCount;
    assign chanMode[i*MW +: MW]    = mode;
    assign chanMask[i]             = mask;
    assign reqPend[i]              = req;
    assign tcLatch[i]              = tc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
    end else if (stb.masterClr) begin
      cmdReg <= '0;
    end else if (stb.wrCmd) begin
      cmdReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tempReg <= '0;
    end else if (stb.masterClr) begin
      tempReg <= '0;
    end else if (engTempLd) begin
      tempReg <= engTempData;
    end
  end

  always_comb begin
    rdWord = '0;
    rdData = '0;
    case (stb.rdSel)
      RD_ADDR:   rdWord = curAddrArr[stb.portChan];
      RD_COUNT:  rdWord = curCountArr[stb.portChan];
      default:   rdWord = '0;
    endcase
    case (stb.rdSel)
      RD_ADDR, RD_COUNT: rdData = stb.hiByte ? rdWord[WW-1:HI_LSB] : rdWord[BW-1:0];
      RD_STATUS:         rdData = BW'({reqPend, tcLatch});
      RD_TEMP:           rdData = tempReg;
      default:           rdData = '0;
    endcase
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int NCH = CH_NUM,
  parameter int WW  = WORD_W,
  parameter int BW  = BYTE_W,
  parameter int MW  = MODE_W,
  parameter int PW  = PORT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PW-1:0]     busAddr,
  input  logic [BW-1:0]     busWrData,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output logic [BW-1:0]     busRdData,
  input  logic [NCH-1:0]    engUpd,
  input  logic [WW-1:0]     engAddr,
  input  logic [WW-1:0]     engCount,
  input  logic [NCH-1:0]    engTc,
  input  logic              engTempLd,
  input  logic [BW-1:0]     engTempData,
  output logic [NCH-1:0]    chanMask,
  output logic [NCH*MW-1:0] chanMode,
  output logic [BW-1:0]     cmdReg,
  output logic [NCH-1:0]    reqPend,
  output logic [NCH*WW-1:0] baseAddr,
  output logic [NCH*WW-1:0] baseCount,
  output logic [NCH*WW-1:0] curAddr,
  output logic [NCH*WW-1:0] curCount
);

  strobe_t stb;

  dma_regs_ctrl #(
    .PORT_BITS (PW),
    .CH_BITS   ($clog2(NCH))
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .stb     (stb)
  );

  dma_regs_data #(
    .NCH (NCH),
    .WW  (WW),
    .BW  (BW),
    .MW  (MW),
    .CHB ($clog2(NCH))
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wrData      (busWrData),
    .rdData      (busRdData),
    .engUpd      (engUpd),
    .engAddr     (engAddr),
    .engCount    (engCount),
    .engTc       (engTc),
    .engTempLd   (engTempLd),
    .engTempData (engTempData),
    .chanMask    (chanMask),
    .chanMode    (chanMode),
    .cmdReg      (cmdReg),
    .reqPend     (reqPend),
    .baseAddr    (baseAddr),
    .baseCount   (baseCount),
    .curAddr     (curAddr),
    .curCount    (curCount)
  );

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
  import dma_regs_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic [PORT_W-1:0]        busAddr,
  input logic [BYTE_W-1:0]        busWrData,
  input logic                     busWrEn,
  input logic                     busRdEn,
  input logic [BYTE_W-1:0]        busRdData,
  input logic [CH_NUM-1:0]        engUpd,
  input logic [WORD_W-1:0]        engAddr,
  input logic [CH_NUM-1:0]        engTc,
  input logic [CH_NUM-1:0]        chanMask,
  input logic [CH_NUM*MODE_W-1:0] chanMode,
  input logic [BYTE_W-1:0]        cmdReg,
  input logic [CH_NUM-1:0]        reqPend,
  input logic [CH_NUM*WORD_W-1:0] curAddr
);

  // R5: single-channel mask command
  a_r5_single_mask: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == OFS_MASK1 |=>
      chanMask[$past(busWrData[CH_W-1:0])] == $past(busWrData[CH_W]));

  // R6: mode command stores the upper six data bits
  a_r6_mode_store: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == OFS_MODE |=>
      chanMode[$past(busWrData[CH_W-1:0]) * MODE_W +: MODE_W] ==
        $past(busWrData[BYTE_W-1:BYTE_W-MODE_W]));

  // R8: a terminal count seen last cycle is visible on a status read
  a_r8_tc_latched: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && !busWrEn && busAddr == OFS_CMD && $past(rstN) &&
      !$past(busWrEn && busAddr == OFS_MCLR) |->
      ((busRdData[CH_NUM-1:0] & $past(engTc)) == $past(engTc)));

  // R10: clear-all-masks port
  a_r10_clear_masks: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == OFS_CLRMASK |=> chanMask == '0);

  // R11: master clear
  a_r11_master_clear: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == OFS_MCLR |=>
      (&chanMask) && cmdReg == '0 && reqPend == '0);

  // R13: engine update of channel 0 current address when the host is elsewhere
  a_r13_engine_update: assert property (@(posedge clk) disable iff (!rstN)
    engUpd[0] && !(busWrEn && busAddr == 4'h0) |=>
      curAddr[WORD_W-1:0] == $past(engAddr));

  // R14: unused read offsets return zero
  a_r14_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && !busWrEn &&
      (busAddr == OFS_REQ || busAddr == OFS_MASK1 || busAddr == OFS_MODE ||
       busAddr == OFS_CLRPTR || busAddr == OFS_CLRMASK || busAddr == OFS_LDMASK)
      |-> busRdData == '0);

endmodule

bind dma_chan_regs dma_chan_regs_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .busWrEn   (busWrEn),
  .busRdEn   (busRdEn),
  .busRdData (busRdData),
  .engUpd    (engUpd),
  .engAddr   (engAddr),
  .engTc     (engTc),
  .chanMask  (chanMask),
  .chanMode  (chanMode),
  .cmdReg    (cmdReg),
  .reqPend   (reqPend),
  .curAddr   (curAddr)
);

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;

  logic        clk;
  logic        rstN;
  logic [3:0]  busAddr;
  logic [7:0]  busWrData;
  logic        busWrEn;
  logic        busRdEn;
  logic [7:0]  busRdData;
  logic [3:0]  engUpd;
  logic [15:0] engAddr;
  logic [15:0] engCount;
  logic [3:0]  engTc;
  logic        engTempLd;
  logic [7:0]  engTempData;
  logic [3:0]  chanMask;
  logic [23:0] chanMode;
  logic [7:0]  cmdReg;
  logic [3:0]  reqPend;
  logic [63:0] baseAddr;
  logic [63:0] baseCount;
  logic [63:0] curAddr;
  logic [63:0] curCount;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  dma_chan_regs u_dma_chan_regs (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic       wr;
    logic       rd;
    logic [3:0] a;
    logic [7:0] d;
    logic [7:0] e;
    logic [3:0] tag;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 4'h0, 8'h00, 8'h00, 4'd1},
    '{1'b1, 1'b0, 4'hC, 8'h00, 8'h00, 4'd4},
    '{1'b1, 1'b0, 4'h0, 8'h34, 8'h00, 4'd2},
    '{1'b1, 1'b0, 4'h0, 8'h12, 8'h00, 4'd2},
    '{1'b0, 1'b1, 4'h0, 8'h00, 8'h34, 4'd2},
    '{1'b0, 1'b1, 4'h0, 8'h00, 8'h12, 4'd2},
    '{1'b1, 1'b0, 4'h3, 8'hCD, 8'h00, 4'd2},
    '{1'b1, 1'b0, 4'h3, 8'hAB, 8'h00, 4'd2},
    '{1'b0, 1'b1, 4'h3, 8'h00, 8'hCD, 4'd2},
    '{1'b0, 1'b1, 4'h7, 8'h00, 8'h00, 4'd3},
    '{1'b0, 1'b1, 4'h3, 8'h00, 8'hCD, 4'd3},
    '{1'b0, 1'b1, 4'h9, 8'h00, 8'h00, 4'd14},
    '{1'b0, 1'b1, 4'h3, 8'h00, 8'hAB, 4'd14},
    '{1'b1, 1'b0, 4'h8, 8'h5A, 8'h00, 4'd7},
    '{1'b1, 1'b0, 4'h9, 8'h06, 8'h00, 4'd9},
    '{1'b0, 1'b1, 4'h8, 8'h00, 8'h40, 4'd9},
    '{1'b1, 1'b0, 4'h9, 8'h02, 8'h00, 4'd9},
    '{1'b0, 1'b1, 4'h8, 8'h00, 8'h00, 4'd9},
    '{1'b1, 1'b0, 4'hC, 8'h00, 8'h00, 4'd4},
    '{1'b1, 1'b0, 4'h0, 8'h77, 8'h00, 4'd3},
    '{1'b0, 1'b1, 4'h0, 8'h00, 8'h12, 4'd3},
    '{1'b0, 1'b1, 4'h0, 8'h00, 8'h77, 4'd4}
  };

  function automatic string tagName(input logic [3:0] t);
    case (t)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd7:  return "R7";
      4'd9:  return "R9";
      4'd14: return "R14";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive after the falling edge, settle, state is visible before the rising edge
  task automatic busOpEng(input logic wr, input logic rd, input logic [3:0] a, input logic [7:0] d,
                          input logic [3:0] upd, input logic [3:0] tc, input logic tld);
    @(negedge clk);
    busWrEn   = wr;
    busRdEn   = rd;
    busAddr   = a;
    busWrData = d;
    engUpd    = upd;
    engTc     = tc;
    engTempLd = tld;
    #1;
  endtask

  task automatic busOp(input logic wr, input logic rd, input logic [3:0] a, input logic [7:0] d);
    busOpEng(wr, rd, a, d, 4'h0, 4'h0, 1'b0);
  endtask

  task automatic rdChk(input string tag, input logic [3:0] a, input logic [7:0] e);
    busOp(1'b0, 1'b1, a, 8'h00);
    chk(tag, 64'(busRdData), 64'(e));
  endtask

  task automatic idle();
    busOp(1'b0, 1'b0, 4'h0, 8'h00);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    busAddr = '0; busWrData = '0; busWrEn = 1'b0; busRdEn = 1'b0;
    engUpd = '0; engAddr = '0; engCount = '0; engTc = '0;
    engTempLd = 1'b0; engTempData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;

    // R1 reset state
    chk("R1", 64'(chanMask), 64'hF);
    chk("R1", 64'(cmdReg), 64'h0);
    chk("R1", 64'(reqPend), 64'h0);
    chk("R1", 64'(chanMode), 64'h0);
    chk("R1", curCount, 64'h0);

    for (int i = 0; i < NV; i++) begin
      busOp(VECS[i].wr, VECS[i].rd, VECS[i].a, VECS[i].d);
      if (VECS[i].rd) chk(tagName(VECS[i].tag), 64'(busRdData), 64'(VECS[i].e));
    end
    idle();

    // R7 command, R2 base and current copies
    chk("R7", 64'(cmdReg), 64'h5A);
    chk("R2", 64'(baseAddr[15:0]), 64'h1277);
    chk("R2", 64'(curAddr[15:0]), 64'h1277);
    chk("R2", 64'(baseCount[31:16]), 64'hABCD);
    chk("R2", 64'(curCount[31:16]), 64'hABCD);

    // R6 modes
    busOp(1'b1, 1'b0, 4'hB, 8'h56);
    busOp(1'b1, 1'b0, 4'hB, 8'hC3);
    idle();
    chk("R6", 64'(chanMode[17:12]), 64'h15);
    chk("R6", 64'(chanMode[23:18]), 64'h30);

    // R5 single mask
    busOp(1'b1, 1'b0, 4'hA, 8'h01);
    idle();
    chk("R5", 64'(chanMask), 64'hD);
    busOp(1'b1, 1'b0, 4'hA, 8'h05);
    idle();
    chk("R5", 64'(chanMask), 64'hF);

    // R10 clear all / load all
    busOp(1'b1, 1'b0, 4'hE, 8'hFF);
    idle();
    chk("R10", 64'(chanMask), 64'h0);
    busOp(1'b1, 1'b0, 4'hF, 8'hA5);
    idle();
    chk("R10", 64'(chanMask), 64'h5);

    // R8 terminal count latch and clear on read
    busOpEng(1'b0, 1'b0, 4'h0, 8'h00, 4'h0, 4'h3, 1'b0);
    rdChk("R8", 4'h8, 8'h03);
    rdChk("R8", 4'h8, 8'h00);
    busOpEng(1'b0, 1'b1, 4'h8, 8'h00, 4'h0, 4'h8, 1'b0);
    chk("R8", 64'(busRdData), 64'h00);
    rdChk("R8", 4'h8, 8'h08);

    // R12 temporary register
    engTempData = 8'h9C;
    busOpEng(1'b0, 1'b0, 4'h0, 8'h00, 4'h0, 4'h0, 1'b1);
    rdChk("R12", 4'hD, 8'h9C);

    // R13 engine update of current copies only
    engAddr = 16'hBEEF;
    engCount = 16'h0102;
    busOpEng(1'b0, 1'b0, 4'h0, 8'h00, 4'h2, 4'h0, 1'b0);
    idle();
    chk("R13", 64'(curAddr[31:16]), 64'hBEEF);
    chk("R13", 64'(curCount[31:16]), 64'h0102);
    chk("R13", 64'(baseCount[31:16]), 64'hABCD);
    busOp(1'b1, 1'b0, 4'hC, 8'h00);
    engAddr = 16'h1111;
    engCount = 16'h2222;
    busOpEng(1'b1, 1'b0, 4'h2, 8'h55, 4'h2, 4'h0, 1'b0);
    idle();
    chk("R13", 64'(curAddr[31:16]), 64'hBE55);
    chk("R13", 64'(curCount[31:16]), 64'h2222);
    chk("R13", 64'(baseAddr[31:16]), 64'h0055);

    // R11 master clear with everything non-default and pointer high
    busOp(1'b1, 1'b0, 4'h8, 8'h3C);
    busOp(1'b1, 1'b0, 4'h9, 8'h05);
    busOp(1'b1, 1'b0, 4'hE, 8'h00);
    busOpEng(1'b0, 1'b0, 4'h0, 8'h00, 4'h0, 4'h4, 1'b1);
    busOp(1'b1, 1'b0, 4'hC, 8'h00);
    rdChk("R11", 4'h0, 8'h77);
    busOp(1'b1, 1'b0, 4'hD, 8'h00);
    idle();
    chk("R11", 64'(chanMask), 64'hF);
    chk("R11", 64'(cmdReg), 64'h0);
    chk("R11", 64'(reqPend), 64'h0);
    chk("R11", 64'(chanMode[17:12]), 64'h15);
    rdChk("R11", 4'h8, 8'h00);
    rdChk("R11", 4'hD, 8'h00);
    rdChk("R11", 4'h0, 8'h77);

    // R14 unused offsets read zero without moving the pointer (pointer now high)
    rdChk("R14", 4'hA, 8'h00);
    rdChk("R14", 4'hB, 8'h00);
    rdChk("R14", 4'hC, 8'h00);
    rdChk("R14", 4'hE, 8'h00);
    rdChk("R14", 4'hF, 8'h00);
    rdChk("R14", 4'h0, 8'h12);
    // R14 read and write together: only the write acts (pointer low, write low byte)
    busOp(1'b1, 1'b1, 4'h0, 8'h66);
    rdChk("R14", 4'h0, 8'h12);
    rdChk("R14", 4'h0, 8'h66);

    // R9 request shown in status and on reqPend
    busOp(1'b1, 1'b0, 4'h9, 8'h07);
    idle();
    chk("R9", 64'(reqPend), 64'h8);
    rdChk("R9", 4'h8, 8'h80);

    idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule